// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer registers of a 32-bit processor core that runs in several privilege modes, together with the current status word and one saved status word for each exception mode. The logical registers 0 to 14 are visible at any moment. Some of them exist several times in storage, and the current mode selects which copy is visible. The stack and link registers (13 and 14) have six copies. Registers 8 to 12 have a second copy that only the fast-interrupt mode sees. The program counter is held outside the block. Logical address 15 is therefore not backed by storage.

Banking is done by address translation, not by copying data. Each logical register address and the bank index of the current mode together select one physical entry. A change of mode therefore takes effect in the same clock edge that updates the mode field. There are two synchronous read ports and one write port. The status side accepts the following commands:
- a hardware mode-change request;
- a full or flags-only write to the current or the saved status word, subject to privilege rules;
- a restore that copies the saved status word into the current one, as a flag-setting write to the program counter does.

A rejected command raises a one-cycle `err` pulse and changes nothing.

Mode field encodings (bits 4..0 of a status word): 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined, 0x1F system. Bank indices: user/system 0, fast 1, interrupt 2, supervisor 3, abort 4, undefined 5. Bit 5 is the instruction-set state bit. Bits 31..28 are the condition flags.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high, both read outputs are 0, `err` is 0, the current status word is 0x000000D3 (supervisor mode, both interrupt masks set, bit 5 clear), and every saved status word is 0x000000D3.
- R2: Each read port returns the register addressed in the previous cycle. A read and a write of the same register in one cycle return the old value.
- R3: Registers 13 and 14 have one private copy per bank. A value written in one mode is seen again after leaving that mode and returning to it, and other banks do not see it.
- R4: Registers 8 to 12 have one copy for the fast-interrupt mode and one copy shared by all other modes. Registers 0 to 7 are shared by every mode.
- R5: User and system modes share bank 0. Switching between them leaves registers 13 and 14 unchanged, and neither mode has a saved status word: `saved_q` reads 0 there.
- R6: `mode_req` with a legal encoding replaces bits 4..0 of the current status word and keeps the other bits. An illegal encoding is rejected.
- R7: In user mode, a full write to the current status word changes only bits 31..28.
- R8: In any privileged mode, a full write to the current status word replaces the whole word, and the register view follows the new mode. The write is rejected if it would change bit 5 or if its mode field is illegal.
- R9: A flags-only write changes only bits 31..28 of the selected status word.
- R10: A saved-status write in a mode of bank 0 is rejected.
- R11: `saved_restore` copies the current bank's saved status word into the current status word, and the register view switches to the restored mode. In bank 0 the restore is rejected.
- R12: A rejected command makes `err` high for exactly the following cycle and leaves all state unchanged. A legal command leaves `err` low.
- R13: Register address 15 reads as 0, and a write to it changes no register.
- R14: A register write issued in the same cycle as a mode change lands in the bank of the mode in effect before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 4 | Read port A logical register address |
| rd_data_a | output | 32 | Read port A data, registered |
| rd_addr_b | input | 4 | Read port B logical register address |
| rd_data_b | output | 32 | Read port B data, registered |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write logical address |
| wr_data | input | 32 | Register write data |
| mode_req | input | 1 | Hardware mode-change request |
| mode_new | input | 5 | Requested mode encoding |
| stat_wr | input | 1 | Status word write command |
| stat_sel_saved | input | 1 | 1 selects the saved status word, 0 the current one |
| stat_flags_only | input | 1 | 1 writes only bits 31..28 |
| stat_wdata | input | 32 | Status write data |
| saved_restore | input | 1 | Copy saved status word into current status word |
| stat_q | output | 32 | Current status word |
| saved_q | output | 32 | Saved status word of the current bank, 0 in bank 0 |
| err | output | 1 | One-cycle pulse after a rejected command |

## Verification
The assertions assume that at most one of `mode_req`, `stat_wr` and `saved_restore` is high in a cycle. Priority between them is defined, but the properties describe single commands only. The stimulus issues each status command alone and clears it on the next falling edge. Register writes are the one exception: they are combined with a mode change on purpose, to exercise the bank selection that applies in that cycle. The bench reads only registers it has written since reset, because the storage array itself is not reset.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int BANK_W    = 3;
  localparam int MODE_W    = 5;
  localparam int STATE_BIT = 5;
  localparam int FLAG_W    = 4;

  localparam logic [MODE_W-1:0] M_USER  = 5'h10;
  localparam logic [MODE_W-1:0] M_FAST  = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ   = 5'h12;
  localparam logic [MODE_W-1:0] M_SUPER = 5'h13;
  localparam logic [MODE_W-1:0] M_ABORT = 5'h17;
  localparam logic [MODE_W-1:0] M_UNDEF = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS   = 5'h1F;

  localparam logic [BANK_W-1:0] FAST_BANK = 3'd1;
  localparam logic [31:0]       STAT_RESET = 32'h0000_00D3;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      M_USER, M_FAST, M_IRQ, M_SUPER, M_ABORT, M_UNDEF, M_SYS: mode_legal = 1'b1;
      default: mode_legal = 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      M_FAST:  mode_bank = 3'd1;
      M_IRQ:   mode_bank = 3'd2;
      M_SUPER: mode_bank = 3'd3;
      M_ABORT: mode_bank = 3'd4;
      M_UNDEF: mode_bank = 3'd5;
      default: mode_bank = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bankreg_addr_map.sv
module bankreg_addr_map
  import bankreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FIQ_LO = 8,
  parameter int FIQ_HI = 12,
  parameter int PHYS_W = 5
) (
  input  logic [ADDR_W-1:0] lreg,
  input  logic [BANK_W-1:0] bank,
  output logic [PHYS_W-1:0] preg,
  output logic              valid
);
  localparam int NUM_FIQ   = FIQ_HI - FIQ_LO + 1;
  localparam int FIQ_BASE  = FIQ_HI + 1;
  localparam int STK_BASE  = FIQ_BASE + NUM_FIQ;
  localparam int STK_FIRST = FIQ_HI + 1;
  localparam int STK_LAST  = FIQ_HI + 2;

  int l;
  int b;

  always_comb begin
    l     = int'(lreg);
    b     = int'(bank);
    valid = 1'b1;
    preg  = '0;
    if (l < FIQ_LO) begin
      preg = PHYS_W'(l);
    end else if (l <= FIQ_HI) begin
      if (bank == FAST_BANK) preg = PHYS_W'(FIQ_BASE + l - FIQ_LO);
      else                   preg = PHYS_W'(l);
    end else if (l <= STK_LAST) begin
      preg = PHYS_W'(STK_BASE + 2 * b + (l - STK_FIRST));
    end else begin
      valid = 1'b0;
    end
  end
endmodule

// File: rtl/bankreg_gpr_mem.sv
module bankreg_gpr_mem #(
  parameter int DATA_W = 32,
  parameter int PHYS   = 30,
  parameter int PHYS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PHYS_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ren_a,
  input  logic [PHYS_W-1:0] raddr_a,
  input  logic              ren_b,
  input  logic [PHYS_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [PHYS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= ren_a ? mem[raddr_a] : '0;
      rdata_b <= ren_b ? mem[raddr_b] : '0;
    end
  end

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < PHYS)); // R4
endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
  import bankreg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_req,
  input  logic [MODE_W-1:0] mode_new,
  input  logic              stat_wr,
  input  logic              stat_sel_saved,
  input  logic              stat_flags_only,
  input  logic [DATA_W-1:0] stat_wdata,
  input  logic              saved_restore,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] saved_q,
  output logic [BANK_W-1:0] cur_bank,
  output logic              err
);
  localparam int FLAG_LO = DATA_W - FLAG_W;

  logic [DATA_W-1:0] saved_r [NUM_BANKS];
  logic [DATA_W-1:0] stat_nxt, saved_nxt;
  logic              saved_we, bad;
  logic [MODE_W-1:0] cur_mode;
  logic              has_saved, privileged;

  assign cur_mode   = stat_q[MODE_W-1:0];
  assign cur_bank   = mode_bank(cur_mode);
  assign has_saved  = (cur_bank != '0);
  assign privileged = (cur_mode != M_USER);
  assign saved_q    = has_saved ? saved_r[cur_bank] : '0;

  always_comb begin
    stat_nxt  = stat_q;
    saved_nxt = saved_r[cur_bank];
    saved_we  = 1'b0;
    bad       = 1'b0;
    if (mode_req) begin
      if (mode_legal(mode_new)) stat_nxt[MODE_W-1:0] = mode_new;
      else                      bad = 1'b1;
    end else if (saved_restore) begin
      if (has_saved) stat_nxt = saved_r[cur_bank];
      else           bad = 1'b1;
    end else if (stat_wr) begin
      if (stat_sel_saved) begin
        if (!has_saved) begin
          bad = 1'b1;
        end else if (stat_flags_only) begin
          saved_we = 1'b1;
          saved_nxt[DATA_W-1:FLAG_LO] = stat_wdata[DATA_W-1:FLAG_LO];
        end else if (!mode_legal(stat_wdata[MODE_W-1:0])) begin
          bad = 1'b1;
        end else begin
          saved_we  = 1'b1;
          saved_nxt = stat_wdata;
        end
      end else if (stat_flags_only || !privileged) begin
        stat_nxt[DATA_W-1:FLAG_LO] = stat_wdata[DATA_W-1:FLAG_LO];
      end else if ((stat_wdata[STATE_BIT] != stat_q[STATE_BIT]) ||
                   !mode_legal(stat_wdata[MODE_W-1:0])) begin
        bad = 1'b1;
      end else begin
        stat_nxt = stat_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= DATA_W'(STAT_RESET);
      err    <= 1'b0;
      for (int i = 0; i < NUM_BANKS; i++) saved_r[i] <= DATA_W'(STAT_RESET);
    end else begin
      stat_q <= stat_nxt;
      err    <= bad;
      if (saved_we) saved_r[cur_bank] <= saved_nxt;
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_req, stat_wr, saved_restore})); // R12
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (mode_req && !mode_legal(mode_new)) |=> (err && $stable(stat_q))); // R6
  AST_USER_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (stat_q[MODE_W-1:0] == M_USER && !mode_req) |=>
      (stat_q[FLAG_LO-1:0] == $past(stat_q[FLAG_LO-1:0]))); // R7
  AST_STATE_GUARD: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !stat_sel_saved && !stat_flags_only && !mode_req && !saved_restore &&
     stat_q[MODE_W-1:0] != M_USER && stat_wdata[STATE_BIT] != stat_q[STATE_BIT])
      |=> (err && $stable(stat_q))); // R8
  AST_BANK0_SAVED: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_sel_saved && !mode_req && !saved_restore && cur_bank == '0)
      |=> (err && saved_q == '0)); // R10
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    err |-> $stable(stat_q)); // R12
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int FIQ_LO    = 8,
  parameter int FIQ_HI    = 12,
  parameter int NUM_BANKS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_req,
  input  logic [4:0]        mode_new,
  input  logic              stat_wr,
  input  logic              stat_sel_saved,
  input  logic              stat_flags_only,
  input  logic [DATA_W-1:0] stat_wdata,
  input  logic              saved_restore,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] saved_q,
  output logic              err
);
  localparam int NUM_FIQ  = FIQ_HI - FIQ_LO + 1;
  localparam int PHYS     = FIQ_HI + 1 + NUM_FIQ + 2 * NUM_BANKS;
  localparam int PHYS_W   = $clog2(PHYS);
  localparam int LAST_LOG = FIQ_HI + 2;
  localparam int NPORT    = 3;

  logic [BANK_W-1:0] cur_bank;
  logic [ADDR_W-1:0] map_l [NPORT];
  logic [PHYS_W-1:0] map_p [NPORT];
  logic              map_v [NPORT];

  assign map_l[0] = rd_addr_a;
  assign map_l[1] = rd_addr_b;
  assign map_l[2] = wr_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    bankreg_addr_map #(
      .ADDR_W(ADDR_W), .FIQ_LO(FIQ_LO), .FIQ_HI(FIQ_HI), .PHYS_W(PHYS_W)
    ) u_map (
      .lreg(map_l[g]), .bank(cur_bank), .preg(map_p[g]), .valid(map_v[g])
    );
  end

  bankreg_gpr_mem #(.DATA_W(DATA_W), .PHYS(PHYS), .PHYS_W(PHYS_W)) u_mem (
    .clk(clk), .rst(rst),
    .we(wr_en && map_v[2]), .waddr(map_p[2]), .wdata(wr_data),
    .ren_a(map_v[0]), .raddr_a(map_p[0]),
    .ren_b(map_v[1]), .raddr_b(map_p[1]),
    .rdata_a(rd_data_a), .rdata_b(rd_data_b)
  );

  bankreg_status #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_status (
    .clk(clk), .rst(rst),
    .mode_req(mode_req), .mode_new(mode_new),
    .stat_wr(stat_wr), .stat_sel_saved(stat_sel_saved),
    .stat_flags_only(stat_flags_only), .stat_wdata(stat_wdata),
    .saved_restore(saved_restore),
    .stat_q(stat_q), .saved_q(saved_q), .cur_bank(cur_bank), .err(err)
  );

  AST_PC_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr_a) > LAST_LOG) |=> (rd_data_a == '0)); // R13
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data, stat_wdata, stat_q, saved_q;
  logic        wr_en, mode_req, stat_wr, stat_sel_saved, stat_flags_only, saved_restore, err;
  logic [4:0]  mode_new;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic got_err;

  always #2 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_req(mode_req), .mode_new(mode_new),
    .stat_wr(stat_wr), .stat_sel_saved(stat_sel_saved),
    .stat_flags_only(stat_flags_only), .stat_wdata(stat_wdata),
    .saved_restore(saved_restore),
    .stat_q(stat_q), .saved_q(saved_q), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic idle();
    wr_en = 0; mode_req = 0; stat_wr = 0; stat_sel_saved = 0;
    stat_flags_only = 0; saved_restore = 0;
  endtask

  task automatic do_reset();
    idle();
    rd_addr_a = 0; rd_addr_b = 0; wr_addr = 0; wr_data = 0;
    mode_new = 5'h13; stat_wdata = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    chk_eq("R1 status word", stat_q, 32'hD3);
    chk_eq("R1 saved word", saved_q, 32'hD3);
    chk_eq("R1 read a", rd_data_a, 0);
    chk_eq("R1 read b", rd_data_b, 0);
    chk_eq("R1 err", {31'b0, err}, 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr_a = a;
    @(negedge clk);
    v = rd_data_a;
  endtask

  task automatic mode(input logic [4:0] m);
    mode_req = 1; mode_new = m;
    @(negedge clk);
    mode_req = 0; got_err = err;
  endtask

  task automatic swr(input bit sel_saved, input bit flags, input logic [31:0] d);
    stat_wr = 1; stat_sel_saved = sel_saved; stat_flags_only = flags; stat_wdata = d;
    @(negedge clk);
    stat_wr = 0; stat_sel_saved = 0; stat_flags_only = 0; got_err = err;
  endtask

  task automatic restore();
    saved_restore = 1;
    @(negedge clk);
    saved_restore = 0; got_err = err;
  endtask

  task automatic t_read_ports();
    logic [31:0] v;
    do_reset();
    wr(3, 32'h1111_0003);
    wr(4, 32'h4444_0004);
    rd_addr_a = 3; rd_addr_b = 4;
    @(negedge clk);
    chk_eq("R2 port a", rd_data_a, 32'h1111_0003);
    chk_eq("R2 port b", rd_data_b, 32'h4444_0004);
    wr(5, 32'h55);
    rd_addr_a = 5; wr_en = 1; wr_addr = 5; wr_data = 32'h5555;
    @(negedge clk);
    wr_en = 0;
    chk_eq("R2 read before write", rd_data_a, 32'h55);
    @(negedge clk);
    chk_eq("R2 read after write", rd_data_a, 32'h5555);
    rd(3, v);
  endtask

  task automatic t_stack_banks();
    logic [31:0] v;
    do_reset();
    wr(13, 32'h5C00_0013); wr(14, 32'h5C00_0014);
    mode(5'h12);
    wr(13, 32'h1A00_0013);
    mode(5'h13);
    rd(13, v); chk_eq("R3 supervisor r13", v, 32'h5C00_0013);
    rd(14, v); chk_eq("R3 supervisor r14", v, 32'h5C00_0014);
    mode(5'h12);
    rd(13, v); chk_eq("R3 interrupt r13", v, 32'h1A00_0013);
  endtask

  task automatic t_fast_banks();
    logic [31:0] v;
    do_reset();
    wr(8, 32'h8); wr(12, 32'hC); wr(7, 32'h7);
    mode(5'h11);
    wr(8, 32'hF8);
    rd(8, v); chk_eq("R4 fast r8", v, 32'hF8);
    rd(7, v); chk_eq("R4 shared r7", v, 32'h7);
    mode(5'h17);
    rd(8, v);  chk_eq("R4 abort r8", v, 32'h8);
    rd(12, v); chk_eq("R4 abort r12", v, 32'hC);
    mode(5'h11);
    rd(8, v); chk_eq("R4 fast r8 again", v, 32'hF8);
  endtask

  task automatic t_user_system();
    logic [31:0] v;
    do_reset();
    mode(5'h1F);
    wr(13, 32'h5151);
    mode(5'h10);
    rd(13, v); chk_eq("R5 shared bank r13", v, 32'h5151);
    chk_eq("R5 user status", stat_q, 32'hD0);
    chk_eq("R5 no saved word", saved_q, 0);
    swr(1, 0, 32'hD3);
    chk_eq("R10 saved write rejected", {31'b0, got_err}, 1);
    chk_eq("R10 saved still zero", saved_q, 0);
    restore();
    chk_eq("R11 restore rejected", {31'b0, got_err}, 1);
    chk_eq("R11 status unchanged", stat_q, 32'hD0);
    @(negedge clk);
    chk_eq("R12 err single cycle", {31'b0, err}, 0);
  endtask

  task automatic t_mode_req();
    do_reset();
    mode(5'h15);
    chk_eq("R6 illegal mode err", {31'b0, got_err}, 1);
    chk_eq("R6 illegal mode status", stat_q, 32'hD3);
    mode(5'h1B);
    chk_eq("R12 legal mode no err", {31'b0, got_err}, 0);
    chk_eq("R6 undefined mode status", stat_q, 32'hDB);
  endtask

  task automatic t_user_write();
    do_reset();
    mode(5'h10);
    swr(0, 0, 32'hA000_00D3);
    chk_eq("R7 user write flags only", stat_q, 32'hA000_00D0);
    chk_eq("R7 no err", {31'b0, got_err}, 0);
  endtask

  task automatic t_priv_write();
    logic [31:0] v;
    do_reset();
    wr(13, 32'h33);
    mode(5'h12); wr(13, 32'h22); mode(5'h13);
    swr(0, 0, 32'h0000_00D2);
    chk_eq("R8 full write", stat_q, 32'hD2);
    rd(13, v); chk_eq("R8 view follows mode", v, 32'h22);
    swr(0, 0, 32'h0000_00F2);
    chk_eq("R8 state bit err", {31'b0, got_err}, 1);
    chk_eq("R8 state bit unchanged", stat_q, 32'hD2);
    swr(0, 0, 32'h0000_00D4);
    chk_eq("R8 bad mode err", {31'b0, got_err}, 1);
    chk_eq("R8 bad mode unchanged", stat_q, 32'hD2);
  endtask

  task automatic t_flags();
    do_reset();
    swr(0, 1, 32'h5FFF_FFFF);
    chk_eq("R9 status flags", stat_q, 32'h5000_00D3);
    swr(1, 1, 32'h9FFF_FFFF);
    chk_eq("R9 saved flags", saved_q, 32'h9000_00D3);
    chk_eq("R9 status kept", stat_q, 32'h5000_00D3);
  endtask

  task automatic t_restore();
    logic [31:0] v;
    do_reset();
    mode(5'h12); wr(13, 32'h1313); mode(5'h13);
    swr(1, 0, 32'h6000_00D2);
    chk_eq("R11 saved full write", saved_q, 32'h6000_00D2);
    restore();
    chk_eq("R11 restored status", stat_q, 32'h6000_00D2);
    chk_eq("R11 interrupt saved word", saved_q, 32'hD3);
    rd(13, v); chk_eq("R11 view follows restore", v, 32'h1313);
  endtask

  task automatic t_pc_addr();
    logic [31:0] v;
    do_reset();
    wr(0, 32'hAAAA); wr(14, 32'h1414);
    wr(15, 32'hDEAD);
    rd(15, v); chk_eq("R13 addr 15 reads zero", v, 0);
    rd(0, v);  chk_eq("R13 r0 untouched", v, 32'hAAAA);
    rd(14, v); chk_eq("R13 r14 untouched", v, 32'h1414);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    do_reset();
    wr(13, 32'h1);
    mode(5'h12); wr(13, 32'h2); mode(5'h13);
    wr_en = 1; wr_addr = 13; wr_data = 32'h3C; mode_req = 1; mode_new = 5'h12;
    @(negedge clk);
    wr_en = 0; mode_req = 0;
    rd(13, v); chk_eq("R14 new bank untouched", v, 32'h2);
    mode(5'h13);
    rd(13, v); chk_eq("R14 old bank written", v, 32'h3C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_read_ports();
    t_stack_banks();
    t_fast_banks();
    t_user_system();
    t_mode_req();
    t_user_write();
    t_priv_write();
    t_flags();
    t_restore();
    t_pc_addr();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule